// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block drives a single-wire, open-drain bus from a small register window. Software programs a time divider so that the system clock is cut down to a one-microsecond tick. It then launches one bus operation at a time by setting a command bit in the control register. The available operations are a bus reset with presence detection, a write-zero slot, and a write-one slot that also reads the bit the bus returns. Each command bit stays set while its operation runs and clears itself when the operation ends. Software polls for that clear and then reads the presence flag or the sampled bit.

The bus is modelled as a wire with a pull-up. The block pulls the line low by raising `line_oe` and reads the line back on `line_in`, which first passes through a configurable synchronizer. A soft-reset register holds the sequencer, the prescaler and the status flags in their idle state for as long as its bit is set.

Top module: `owire_master`

## Requirements
- R1: After `rst_n` is asserted, the control register (address 0) reads 0x00, the divider register (address 2) reads 0x00, the soft-reset register (address 4) reads 0x00, and `line_oe` is low.
- R2: The divider register at address 2 reads back what was written. Every bus timing below is counted in ticks, and one tick lasts (divider + 1) clock cycles. The prescaler starts from zero when a command is accepted, so tick n of a command falls n·(divider+1) cycles after the edge that accepted it.
- R3: Writing control bit 7 while the block is idle starts a reset sequence. The bus is pulled low for 511 ticks, and bit 7 reads 1 for 1023 ticks in total before it clears.
- R4: Control bit 6 reads 1 after a reset sequence only if the synchronized line was seen low at some tick from the 15th to the 240th after the bus was released (ticks numbered from 1). Starting a reset sequence clears the bit.
- R5: Writing control bit 5 while idle starts a write-zero slot. The bus is low for 60 ticks, and bit 5 reads 1 for 62 ticks.
- R6: Writing control bit 4 while idle starts a write-one/read slot. The bus is low for 5 ticks, and bit 4 reads 1 for 62 ticks.
- R7: At the end of a write-one/read slot, control bit 3 holds the synchronized line level sampled at the 15th tick of that slot.
- R8: If one control write sets several command bits, exactly one command runs. Bit 7 wins over bit 5, and bit 5 wins over bit 4.
- R9: A control write made while any command is running is ignored. It neither starts a second command nor changes the running one or its duration.
- R10: Writing 1 to bit 0 of address 4 aborts any running command on the next cycle, releases the bus and clears control bits 7 to 3. While the bit reads 1, command writes are ignored. The divider value is kept. Writing 0 returns the block to normal operation.
- R11: The line input passes through SYNC_STAGES flip-flops, 2 by default, that reset to the high level. A line level is seen by the sequencer SYNC_STAGES cycles after it is presented.
- R12: `line_oe` is high only while a command is running. Every command starts by pulling the bus low and ends with the bus released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 3 | Byte address: 0 control, 2 divider, 4 soft reset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| line_in | input | 1 | Level of the bus wire |
| line_oe | output | 1 | High pulls the bus wire low; low releases it |

## Verification
The presence window is probed with a one-cycle pull-down placed exactly on the 14th, 15th, 240th and 241st tick after release, and once with no responder. Only the two inner positions may raise the flag, which separates an off-by-one window edge from a correct one. The read sample is probed the same way on ticks 13 to 17, and only tick 15 may return zero. The low time and the busy time of every command are counted in cycles for divider values 0, 1 and 3, so a prescaler that divides by the register value instead of the value plus one, or that keeps a stale phase, shows up as a wrong count. Multi-bit command writes, writes made during a running slot, and a soft reset issued mid-sequence check the priority order, the busy lockout and the abort path.

// File: rtl/owm_pkg.sv
package owm_pkg;

   // register byte addresses; software depends on them
   localparam logic [2:0] ADDR_CTRL = 3'h0;
   localparam logic [2:0] ADDR_DIV  = 3'h2;
   localparam logic [2:0] ADDR_SRST = 3'h4;

   // control register bit positions
   localparam int BIT_RESET = 7;
   localparam int BIT_PRES  = 6;
   localparam int BIT_WR0   = 5;
   localparam int BIT_WR1   = 4;
   localparam int BIT_RDVAL = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RST_LOW,
      ST_PRES_WIN,
      ST_SLOT
   } ow_state_e;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_RESET,
      CMD_WR0,
      CMD_WR1
   } ow_cmd_e;

endpackage

// File: rtl/owm_prescaler.sv
module owm_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || cnt_q == div) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = !clear && (cnt_q == div);

endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s
);

   if (STAGES == 0) begin : g_direct
      assign line_s = line_in;
   end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '1;
         end else if (STAGES == 1) begin
            sync_q <= line_in;
         end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
         end
      end
      assign line_s = sync_q[STAGES-1];
   end

endmodule

// File: rtl/owm_seq.sv
module owm_seq
   import owm_pkg::*;
#(
   parameter int RST_LOW_TICKS  = 511,
   parameter int PRES_WIN_TICKS = 512,
   parameter int PRES_FIRST     = 15,
   parameter int PRES_LAST      = 240,
   parameter int WR0_LOW_TICKS  = 60,
   parameter int WR1_LOW_TICKS  = 5,
   parameter int SAMPLE_TICK    = 15,
   parameter int SLOT_TICKS     = 62
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    srst,
   input  logic    start,
   input  ow_cmd_e start_cmd,
   input  logic    tick,
   input  logic    line_s,
   output logic    busy,
   output ow_cmd_e cur_cmd,
   output logic    presence,
   output logic    rd_bit,
   output logic    drive_low
);

   localparam int MAX_AB = (RST_LOW_TICKS > PRES_WIN_TICKS) ? RST_LOW_TICKS : PRES_WIN_TICKS;
   localparam int MAX_T  = (MAX_AB > SLOT_TICKS) ? MAX_AB : SLOT_TICKS;
   localparam int CNT_W  = $clog2(MAX_T + 1);

   localparam logic [CNT_W-1:0] RST_END  = CNT_W'(RST_LOW_TICKS - 1);
   localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(PRES_WIN_TICKS - 1);
   localparam logic [CNT_W-1:0] WIN_LO   = CNT_W'(PRES_FIRST - 1);
   localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(PRES_LAST - 1);
   localparam logic [CNT_W-1:0] WR0_END  = CNT_W'(WR0_LOW_TICKS - 1);
   localparam logic [CNT_W-1:0] WR1_END  = CNT_W'(WR1_LOW_TICKS - 1);
   localparam logic [CNT_W-1:0] SAMP_AT  = CNT_W'(SAMPLE_TICK - 1);
   localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(SLOT_TICKS - 1);

   ow_state_e        state_q;
   ow_cmd_e          cmd_q;
   logic [CNT_W-1:0] tcnt_q;
   logic [CNT_W-1:0] rel_at;
   logic             in_win;
   logic             oe_q, pres_q, rbit_q;

   always_comb begin
      rel_at = (cmd_q == CMD_WR0) ? WR0_END : WR1_END;
      in_win = (tcnt_q >= WIN_LO) && (tcnt_q <= WIN_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= CMD_NONE;
         tcnt_q  <= '0;
         oe_q    <= 1'b0;
         pres_q  <= 1'b0;
         rbit_q  <= 1'b0;
      end else if (srst) begin
         state_q <= ST_IDLE;
         cmd_q   <= CMD_NONE;
         tcnt_q  <= '0;
         oe_q    <= 1'b0;
         pres_q  <= 1'b0;
         rbit_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start && start_cmd != CMD_NONE) begin
                  cmd_q  <= start_cmd;
                  tcnt_q <= '0;
                  oe_q   <= 1'b1;
                  if (start_cmd == CMD_RESET) begin
                     state_q <= ST_RST_LOW;
                     pres_q  <= 1'b0;
                  end else begin
                     state_q <= ST_SLOT;
                  end
               end
            end
            ST_RST_LOW: begin
               if (tick) begin
                  if (tcnt_q == RST_END) begin
                     state_q <= ST_PRES_WIN;
                     tcnt_q  <= '0;
                     oe_q    <= 1'b0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            ST_PRES_WIN: begin
               if (tick) begin
                  if (in_win && !line_s) begin
                     pres_q <= 1'b1;
                  end
                  if (tcnt_q == WIN_END) begin
                     state_q <= ST_IDLE;
                     cmd_q   <= CMD_NONE;
                     tcnt_q  <= '0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            ST_SLOT: begin
               if (tick) begin
                  if (tcnt_q == rel_at) begin
                     oe_q <= 1'b0;
                  end
                  if (cmd_q == CMD_WR1 && tcnt_q == SAMP_AT) begin
                     rbit_q <= line_s;
                  end
                  if (tcnt_q == SLOT_END) begin
                     state_q <= ST_IDLE;
                     cmd_q   <= CMD_NONE;
                     tcnt_q  <= '0;
                     oe_q    <= 1'b0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
               cmd_q   <= CMD_NONE;
               oe_q    <= 1'b0;
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign cur_cmd   = cmd_q;
   assign presence  = pres_q;
   assign rd_bit    = rbit_q;
   assign drive_low = oe_q;

endmodule

// File: rtl/owire_master.sv
module owire_master
   import owm_pkg::*;
#(
   parameter int          DIV_W          = 8,
   parameter int          DIV_RESET      = 0,
   parameter int          SYNC_STAGES    = 2,
   parameter int          RST_LOW_TICKS  = 511,
   parameter int          PRES_WIN_TICKS = 512,
   parameter int          PRES_FIRST     = 15,
   parameter int          PRES_LAST      = 240,
   parameter int          WR0_LOW_TICKS  = 60,
   parameter int          WR1_LOW_TICKS  = 5,
   parameter int          SAMPLE_TICK    = 15,
   parameter int          SLOT_TICKS     = 62
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       line_in,
   output logic       line_oe
);

   // elaboration-time parameter checks
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div_w
      $error("owire_master: DIV_W must be 1..8");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("owire_master: SYNC_STAGES must be 0..3");
   end
   if (SLOT_TICKS > 120 || SLOT_TICKS <= WR0_LOW_TICKS) begin : g_bad_slot
      $error("owire_master: slot length must exceed write-0 low time and stay within 120 ticks");
   end
   if (SAMPLE_TICK <= WR1_LOW_TICKS || SAMPLE_TICK > SLOT_TICKS) begin : g_bad_sample
      $error("owire_master: sample tick must follow release and lie inside the slot");
   end
   if (PRES_FIRST < 1 || PRES_FIRST > PRES_LAST || PRES_LAST > PRES_WIN_TICKS) begin : g_bad_win
      $error("owire_master: presence window out of range");
   end
   if (RST_LOW_TICKS < 1 || WR1_LOW_TICKS < 1) begin : g_bad_low
      $error("owire_master: low phases need at least one tick");
   end

   logic [DIV_W-1:0] div_q;
   logic             srst_q;
   logic             seq_busy;
   ow_cmd_e          seq_cmd;
   logic             seq_pres, seq_rbit;
   logic             tick, line_s;
   logic             ctrl_wr, start;
   ow_cmd_e          req_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(DIV_RESET);
         srst_q <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
         if (reg_addr == ADDR_SRST) srst_q <= reg_wdata[0];
      end
   end

   // one command per write; reset outranks write-0, which outranks write-1
   always_comb begin
      if (reg_wdata[BIT_RESET])    req_cmd = CMD_RESET;
      else if (reg_wdata[BIT_WR0]) req_cmd = CMD_WR0;
      else if (reg_wdata[BIT_WR1]) req_cmd = CMD_WR1;
      else                         req_cmd = CMD_NONE;
   end

   assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
   assign start   = ctrl_wr && !seq_busy && !srst_q;

   owm_prescaler #(
      .DIV_W (DIV_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!seq_busy),
      .div   (div_q),
      .tick  (tick)
   );

   owm_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .line_s  (line_s)
   );

   owm_seq #(
      .RST_LOW_TICKS  (RST_LOW_TICKS),
      .PRES_WIN_TICKS (PRES_WIN_TICKS),
      .PRES_FIRST     (PRES_FIRST),
      .PRES_LAST      (PRES_LAST),
      .WR0_LOW_TICKS  (WR0_LOW_TICKS),
      .WR1_LOW_TICKS  (WR1_LOW_TICKS),
      .SAMPLE_TICK    (SAMPLE_TICK),
      .SLOT_TICKS     (SLOT_TICKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst_q),
      .start     (start),
      .start_cmd (req_cmd),
      .tick      (tick),
      .line_s    (line_s),
      .busy      (seq_busy),
      .cur_cmd   (seq_cmd),
      .presence  (seq_pres),
      .rd_bit    (seq_rbit),
      .drive_low (line_oe)
   );

   always_comb begin
      reg_rdata = 8'h00;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[BIT_RESET] = (seq_cmd == CMD_RESET);
            reg_rdata[BIT_PRES]  = seq_pres;
            reg_rdata[BIT_WR0]   = (seq_cmd == CMD_WR0);
            reg_rdata[BIT_WR1]   = (seq_cmd == CMD_WR1);
            reg_rdata[BIT_RDVAL] = seq_rbit;
         end
         ADDR_DIV:  reg_rdata = 8'(div_q);
         ADDR_SRST: reg_rdata = {7'b0, srst_q};
         default:   reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/owm_chk.sv
module owm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       srst,
   input logic       busy,
   input logic [1:0] cmd,
   input logic       line_oe
);

   // R12
   oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> busy);

   // R12
   start_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> line_oe);

   // R12
   end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !line_oe);

   // R9
   no_cmd_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(cmd)));

   // R10
   srst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!busy && !line_oe));

endmodule

bind owire_master owm_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .srst    (srst_q),
   .busy    (seq_busy),
   .cmd     (seq_cmd),
   .line_oe (line_oe)
);

// File: tb/owire_master_bench.sv
`timescale 1ns/1ps
module owire_master_bench;

   localparam int SYNC  = 2;
   localparam int T_RL  = 511;
   localparam int T_RW  = 512;
   localparam int T_W0  = 60;
   localparam int T_W1  = 5;
   localparam int T_SL  = 62;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       line_oe;
   logic       dev_low = 1'b0;
   logic       line_w;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   assign line_w = !(line_oe || dev_low);

   owire_master #(.SYNC_STAGES(SYNC)) u_owire_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .line_in   (line_w),
      .line_oe   (line_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
      reg_addr = 3'd0;
   endtask

   // launch a command; optionally pull the line for one cycle so that the
   // sequencer sees it at edge pull_at after the accepting edge
   task automatic run_cmd(input logic [7:0] cmd, input int pull_at,
                          output int low_c, output int busy_c, output logic [7:0] fin);
      int lc = 0;
      int bc = 0;
      wr(3'd0, cmd);
      fork
         begin
            if (pull_at > 0) begin
               repeat (pull_at - SYNC - 1) @(negedge clk);
               dev_low = 1'b1;
               @(negedge clk);
               dev_low = 1'b0;
            end
         end
         begin
            for (int g = 0; g < 20000; g++) begin
               if (line_oe) lc++;
               if ((reg_rdata & 8'hB0) != 8'h00) bc++;
               else break;
               @(negedge clk);
            end
         end
      join
      low_c = lc; busy_c = bc; fin = reg_rdata;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v, fin;
      int lc, bc;
      int divs[3] = '{0, 1, 3};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd2, v); chk("R1 div", v, 0);
      rd(3'd4, v); chk("R1 srst", v, 0);
      chk("R1 line_oe", line_oe, 0);

      foreach (divs[i]) begin
         int d = divs[i];
         wr(3'd2, 8'(d));
         rd(3'd2, v); chk("R2 div readback", v, d);
         // R5 write-0 slot
         run_cmd(8'h20, 0, lc, bc, fin);
         chk("R5 wr0 low", lc, T_W0 * (d + 1));
         chk("R5 wr0 busy", bc, T_SL * (d + 1));
         // R6 / R7 read slot, sample sweep over ticks 13..17
         for (int n = 13; n <= 17; n++) begin
            run_cmd(8'h10, n * (d + 1), lc, bc, fin);
            chk("R6 wr1 low", lc, T_W1 * (d + 1));
            chk("R6 wr1 busy", bc, T_SL * (d + 1));
            chk("R7 read bit", int'(fin[3]), (n == 15) ? 0 : 1);
         end
         run_cmd(8'h10, 0, lc, bc, fin);
         chk("R7 read bit idle line", int'(fin[3]), 1);
      end

      // R3 / R4 reset and presence window boundaries
      for (int d = 0; d <= 1; d++) begin
         int ns[5] = '{14, 15, 240, 241, 0};
         wr(3'd2, 8'(d));
         foreach (ns[k]) begin
            int n = ns[k];
            run_cmd(8'h80, (n == 0) ? 0 : (T_RL + n) * (d + 1), lc, bc, fin);
            chk("R3 reset low", lc, T_RL * (d + 1));
            chk("R3 reset busy", bc, (T_RL + T_RW) * (d + 1));
            chk("R4 presence", int'(fin[6]), (n >= 15 && n <= 240) ? 1 : 0);
            chk("R11 sync alignment", int'(fin[6]), (n == 15 || n == 240) ? 1 : 0);
         end
      end

      wr(3'd2, 8'd0);
      // R8 priority
      run_cmd(8'hB0, 0, lc, bc, fin);
      chk("R8 bit7 wins low", lc, T_RL);
      chk("R8 bit7 wins busy", bc, T_RL + T_RW);
      run_cmd(8'h30, 0, lc, bc, fin);
      chk("R8 bit5 over bit4 low", lc, T_W0);
      chk("R8 bit5 over bit4 busy", bc, T_SL);

      // R9 write during running slot is ignored
      fork
         run_cmd(8'h10, 0, lc, bc, fin);
         begin
            repeat (8) @(negedge clk);
            wr(3'd0, 8'h80);
         end
      join
      chk("R9 busy unchanged", bc, T_SL);
      chk("R9 low unchanged", lc, T_W1);
      chk("R9 no reset started", int'(fin & 8'hF0), 0);

      // R10 soft reset mid-sequence, after a presence hit
      run_cmd(8'h80, T_RL + 100, lc, bc, fin);
      chk("R4 presence set before srst", int'(fin[6]), 1);
      wr(3'd2, 8'd2);
      wr(3'd0, 8'h80);
      repeat (20) @(negedge clk);
      wr(3'd4, 8'h01);
      @(negedge clk);
      rd(3'd0, v); chk("R10 ctrl cleared", v, 0);
      chk("R10 line released", line_oe, 0);
      wr(3'd0, 8'h10);
      @(negedge clk);
      rd(3'd0, v); chk("R10 cmd ignored in srst", v, 0);
      chk("R10 line stays released", line_oe, 0);
      rd(3'd4, v); chk("R10 srst readback", v, 1);
      rd(3'd2, v); chk("R10 div kept", v, 2);
      wr(3'd4, 8'h00);
      run_cmd(8'h20, 0, lc, bc, fin);
      chk("R10 wr0 after release low", lc, T_W0 * 3);
      chk("R10 wr0 after release busy", bc, T_SL * 3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule